// File: doc/BRIEF.md
# Time-Multiplexed Integrate-and-Fire Neuron Core

This block is a digital neurosynaptic core. A bank of neurons keeps its membrane potentials in local storage, and a single shared update engine serves all of them. Input spike events each name one input axon. They are latched into an axon buffer and held there until the next global tick. On a tick, the engine visits the neurons one per cycle in ascending index order. For each neuron it adds up the contributions of the axons that spiked and are connected to it. It then subtracts the neuron's leak and compares the result with the neuron's threshold. A neuron that fires has its potential replaced by its reset value and emits an output spike event that carries its index.

Connectivity is a binary crossbar with one row per neuron and one bit per axon. Each axon also carries a 2-bit type code. The synaptic weight is not stored per synapse. Each neuron instead holds four weights, and the axon's type selects which of them applies. All configuration (crossbar rows, axon types, weights, leak, threshold and reset value) is loaded through a single write port. The axon buffer has two banks, so spikes that arrive during a sweep are kept for the following tick. Output events leave through a valid/ready handshake, and the sweep waits while an event is not taken.

Top module: `neu_core`

## Requirements
- R1: After reset `busy`, `done`, `overrun` and `out_valid` are 0, every membrane potential is 0 and all configuration is 0, so a tick with nothing configured emits no spike.
- R2: A neuron's integration sum is the total of its weights over the axons that both spiked since the previous accepted tick and have a 1 in that neuron's crossbar row. An axon of type code t (0..3) contributes the neuron's weight number t.
- R3: A neuron's own signed leak value is subtracted from its potential exactly once on every tick, whether or not any spike arrived.
- R4: A neuron fires only when its updated potential is strictly greater than its signed threshold. A firing neuron's potential becomes its reset value and it emits one output event carrying its index. A neuron whose potential equals its threshold does not fire.
- R5: The potential is 20-bit signed. The update is computed at full precision and then clamped to the range -524288..524287 instead of wrapping.
- R6: A spike accepted while a sweep runs is applied on the next tick and not on the current one. Each buffered spike is applied on exactly one tick, after which its buffer entry is cleared.
- R7: A tick that arrives while `busy` is 1 sets `overrun`, which stays 1 until reset, and otherwise has no effect (no extra sweep, no extra `done`).
- R8: An accepted tick raises `busy` on the next cycle. The neurons are visited in ascending index order, so output events leave in ascending index order within a tick. `done` pulses for exactly one cycle when `busy` falls after the last neuron.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_neuron` holds its value and the sweep does not advance.
- R10: A configuration write is taken when `cfg_we` is 1, with `cfg_kind` selecting the target: 0 = crossbar row of neuron `cfg_addr` from `cfg_row`, 1 = type of axon `cfg_addr` from `cfg_data[1:0]`, 2 = weight `cfg_sub` of neuron `cfg_addr`, 3 = leak, 4 = threshold, 5 = reset value of neuron `cfg_addr`, the values in each case taken from the 9-bit signed `cfg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Configuration target select (see R10) |
| cfg_addr | input | 8 | Neuron or axon index of the write |
| cfg_sub | input | 2 | Weight slot for weight writes |
| cfg_data | input | 9 | Signed value or axon type for the write |
| cfg_row | input | 256 | Crossbar row for row writes, bit i = axon i |
| spk_valid | input | 1 | Input spike event strobe |
| spk_axon | input | 8 | Axon index of the input spike |
| tick | input | 1 | Global time step request |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at sweep end |
| overrun | output | 1 | Sticky: a tick arrived during a sweep |
| out_valid | output | 1 | Output spike event valid |
| out_ready | input | 1 | Output spike event accepted |
| out_neuron | output | 8 | Index of the firing neuron |

## Verification
Membrane potentials are visible only through firing. A wrong potential, leak, clamp or crossbar bit therefore shows up as a spike that is missing, extra or late on some later tick, often several ticks after the fault. The bench keeps a reference potential for every neuron and compares the complete ordered event list of each tick. Directed sequences fix when a given neuron must first fire: equality with the threshold, leak-only drift, and recovery from negative saturation, where a wrapping or unclamped result would move the first firing by one tick. A buffer bank that is mis-steered or not cleared shows up within one or two ticks as an event one tick early or repeated.

// File: rtl/neu_pkg.sv
package neu_pkg;

   typedef enum logic [2:0] {
      CFG_XBAR   = 3'd0,
      CFG_TYPE   = 3'd1,
      CFG_WEIGHT = 3'd2,
      CFG_LEAK   = 3'd3,
      CFG_THRESH = 3'd4,
      CFG_RESET  = 3'd5
   } cfg_kind_e;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_e;

endpackage

// File: rtl/neu_axon_buf.sv
module neu_axon_buf #(
   parameter int N_AX = 256,
   localparam int AX_W = $clog2(N_AX)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            spk_valid,
   input  logic [AX_W-1:0] spk_axon,
   input  logic            swap,
   input  logic            clear_proc,
   output logic [N_AX-1:0] proc_bits
);

   logic [N_AX-1:0] bank_q [2];
   logic            fill_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_sel <= 1'b0;
      end else if (swap) begin
         fill_sel <= ~fill_sel;
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q[b] <= '0;
         end else begin
            if (clear_proc && (fill_sel != 1'(b))) begin
               bank_q[b] <= '0;
            end else if (spk_valid && (fill_sel == 1'(b)) && (int'(spk_axon) < N_AX)) begin
               bank_q[b][spk_axon] <= 1'b1;
            end
         end
      end
   end

   assign proc_bits = bank_q[~fill_sel];

endmodule

// File: rtl/neu_cfg_store.sv
module neu_cfg_store
   import neu_pkg::*;
#(
   parameter int N_NEU  = 256,
   parameter int N_AX   = 256,
   parameter int TYPE_W = 2,
   parameter int VAL_W  = 9,
   localparam int IDX_W  = $clog2(N_NEU),
   localparam int AX_W   = $clog2(N_AX),
   localparam int ADDR_W = (IDX_W > AX_W) ? IDX_W : AX_W,
   localparam int NT     = 1 << TYPE_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [2:0]             kind,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [TYPE_W-1:0]      sub,
   input  logic [VAL_W-1:0]       data,
   input  logic [N_AX-1:0]        row,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [N_AX-1:0]        rd_row,
   output logic [N_AX*TYPE_W-1:0] types_flat,
   output logic [NT*VAL_W-1:0]    rd_w_flat,
   output logic [VAL_W-1:0]       rd_leak,
   output logic [VAL_W-1:0]       rd_thr,
   output logic [VAL_W-1:0]       rd_rst
);

   logic [N_AX-1:0]   xbar_q [N_NEU];
   logic [TYPE_W-1:0] typ_q  [N_AX];
   logic [VAL_W-1:0]  w_q    [N_NEU][NT];
   logic [VAL_W-1:0]  leak_q [N_NEU];
   logic [VAL_W-1:0]  thr_q  [N_NEU];
   logic [VAL_W-1:0]  rst_q  [N_NEU];

   cfg_kind_e  kind_e;
   logic       neu_ok;
   logic       ax_ok;
   logic [IDX_W-1:0] n_sel;
   logic [AX_W-1:0]  a_sel;

   assign kind_e = cfg_kind_e'(kind);
   assign neu_ok = (int'(addr) < N_NEU);
   assign ax_ok  = (int'(addr) < N_AX);
   assign n_sel  = addr[IDX_W-1:0];
   assign a_sel  = addr[AX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < N_NEU; n++) begin
            xbar_q[n] <= '0;
            leak_q[n] <= '0;
            thr_q[n]  <= '0;
            rst_q[n]  <= '0;
            for (int t = 0; t < NT; t++) begin
               w_q[n][t] <= '0;
            end
         end
         for (int a = 0; a < N_AX; a++) begin
            typ_q[a] <= '0;
         end
      end else if (we) begin
         case (kind_e)
            CFG_XBAR:   if (neu_ok) xbar_q[n_sel] <= row;
            CFG_TYPE:   if (ax_ok)  typ_q[a_sel]  <= data[TYPE_W-1:0];
            CFG_WEIGHT: if (neu_ok) w_q[n_sel][sub] <= data;
            CFG_LEAK:   if (neu_ok) leak_q[n_sel] <= data;
            CFG_THRESH: if (neu_ok) thr_q[n_sel]  <= data;
            CFG_RESET:  if (neu_ok) rst_q[n_sel]  <= data;
            default: ;
         endcase
      end
   end

   for (genvar a = 0; a < N_AX; a++) begin : g_type_pack
      assign types_flat[a*TYPE_W +: TYPE_W] = typ_q[a];
   end

   for (genvar t = 0; t < NT; t++) begin : g_w_pack
      assign rd_w_flat[t*VAL_W +: VAL_W] = w_q[rd_idx][t];
   end

   assign rd_row  = xbar_q[rd_idx];
   assign rd_leak = leak_q[rd_idx];
   assign rd_thr  = thr_q[rd_idx];
   assign rd_rst  = rst_q[rd_idx];

endmodule

// File: rtl/neu_integrator.sv
module neu_integrator #(
   parameter int N_AX   = 256,
   parameter int TYPE_W = 2,
   parameter int VAL_W  = 9,
   parameter int POT_W  = 20,
   localparam int NT    = 1 << TYPE_W,
   localparam int SUM_W = VAL_W + $clog2(N_AX) + 1,
   localparam int EXT_W = ((POT_W > SUM_W) ? POT_W : SUM_W) + 2
) (
   input  logic [N_AX-1:0]        active,
   input  logic [N_AX*TYPE_W-1:0] types_flat,
   input  logic [NT*VAL_W-1:0]    w_flat,
   input  logic [POT_W-1:0]       pot,
   input  logic [VAL_W-1:0]       leak,
   input  logic [VAL_W-1:0]       thr,
   input  logic [VAL_W-1:0]       rstv,
   output logic [POT_W-1:0]       pot_next,
   output logic                   fire
);

   localparam logic signed [EXT_W-1:0] POT_MAX =
      {{(EXT_W-POT_W+1){1'b0}}, {(POT_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] POT_MIN =
      {{(EXT_W-POT_W+1){1'b1}}, {(POT_W-1){1'b0}}};

   logic signed [EXT_W-1:0] term [N_AX];
   logic signed [EXT_W-1:0] syn_sum;
   logic signed [EXT_W-1:0] raw;
   logic signed [EXT_W-1:0] clamped;
   logic signed [EXT_W-1:0] thr_ext;

   for (genvar g = 0; g < N_AX; g++) begin : g_lane
      logic [TYPE_W-1:0] lane_type;
      logic [VAL_W-1:0]  lane_w;
      assign lane_type = types_flat[g*TYPE_W +: TYPE_W];
      assign lane_w    = w_flat[lane_type*VAL_W +: VAL_W];
      assign term[g]   = active[g] ? {{(EXT_W-VAL_W){lane_w[VAL_W-1]}}, lane_w} : '0;
   end

   always_comb begin
      syn_sum = '0;
      for (int i = 0; i < N_AX; i++) begin
         syn_sum = syn_sum + term[i];
      end
   end

   always_comb begin
      raw = {{(EXT_W-POT_W){pot[POT_W-1]}}, pot} + syn_sum
            - {{(EXT_W-VAL_W){leak[VAL_W-1]}}, leak};
      if (raw > POT_MAX) begin
         clamped = POT_MAX;
      end else if (raw < POT_MIN) begin
         clamped = POT_MIN;
      end else begin
         clamped = raw;
      end
      thr_ext  = {{(EXT_W-VAL_W){thr[VAL_W-1]}}, thr};
      fire     = (clamped > thr_ext);
      pot_next = fire ? {{(POT_W-VAL_W){rstv[VAL_W-1]}}, rstv} : clamped[POT_W-1:0];
   end

endmodule

// File: rtl/neu_core.sv
module neu_core
   import neu_pkg::*;
#(
   parameter int N_NEU  = 256,
   parameter int N_AX   = 256,
   parameter int TYPE_W = 2,
   parameter int VAL_W  = 9,
   parameter int POT_W  = 20,
   localparam int IDX_W  = $clog2(N_NEU),
   localparam int AX_W   = $clog2(N_AX),
   localparam int ADDR_W = (IDX_W > AX_W) ? IDX_W : AX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_kind,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [TYPE_W-1:0] cfg_sub,
   input  logic [VAL_W-1:0]  cfg_data,
   input  logic [N_AX-1:0]   cfg_row,
   input  logic              spk_valid,
   input  logic [AX_W-1:0]   spk_axon,
   input  logic              tick,
   output logic              busy,
   output logic              done,
   output logic              overrun,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [IDX_W-1:0]  out_neuron
);

   localparam int NT = 1 << TYPE_W;

   if (N_NEU < 2)              begin : g_chk_neu  $error("N_NEU must be at least 2");       end
   if (N_AX < 2)               begin : g_chk_ax   $error("N_AX must be at least 2");        end
   if (TYPE_W < 1)             begin : g_chk_typ  $error("TYPE_W must be at least 1");      end
   if (TYPE_W > VAL_W)         begin : g_chk_tv   $error("TYPE_W must fit in VAL_W");       end
   if (POT_W <= VAL_W)         begin : g_chk_pot  $error("POT_W must exceed VAL_W");        end

   eng_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [POT_W-1:0]  pot_q [N_NEU];
   logic              done_q;
   logic              ovr_q;
   logic              ov_valid_q;
   logic [IDX_W-1:0]  ov_idx_q;

   logic [N_AX-1:0]        proc_bits;
   logic [N_AX-1:0]        row;
   logic [N_AX*TYPE_W-1:0] types_flat;
   logic [NT*VAL_W-1:0]    w_flat;
   logic [VAL_W-1:0]       leak, thr, rstv;
   logic [POT_W-1:0]       pot_next;
   logic                   fire;

   logic tick_go;
   logic proceed;
   logic last;
   logic step;

   assign tick_go = tick && (state_q == ENG_IDLE);
   assign proceed = !ov_valid_q || out_ready;
   assign last    = (idx_q == IDX_W'(N_NEU - 1));
   assign step    = (state_q == ENG_RUN) && proceed;

   neu_axon_buf #(.N_AX(N_AX)) axbuf_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .spk_valid  (spk_valid),
      .spk_axon   (spk_axon),
      .swap       (tick_go),
      .clear_proc (step && last),
      .proc_bits  (proc_bits)
   );

   neu_cfg_store #(
      .N_NEU(N_NEU), .N_AX(N_AX), .TYPE_W(TYPE_W), .VAL_W(VAL_W)
   ) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .kind       (cfg_kind),
      .addr       (cfg_addr),
      .sub        (cfg_sub),
      .data       (cfg_data),
      .row        (cfg_row),
      .rd_idx     (idx_q),
      .rd_row     (row),
      .types_flat (types_flat),
      .rd_w_flat  (w_flat),
      .rd_leak    (leak),
      .rd_thr     (thr),
      .rd_rst     (rstv)
   );

   neu_integrator #(
      .N_AX(N_AX), .TYPE_W(TYPE_W), .VAL_W(VAL_W), .POT_W(POT_W)
   ) integ_i (
      .active     (proc_bits & row),
      .types_flat (types_flat),
      .w_flat     (w_flat),
      .pot        (pot_q[idx_q]),
      .leak       (leak),
      .thr        (thr),
      .rstv       (rstv),
      .pot_next   (pot_next),
      .fire       (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ENG_IDLE;
         idx_q      <= '0;
         done_q     <= 1'b0;
         ovr_q      <= 1'b0;
         ov_valid_q <= 1'b0;
         ov_idx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (tick && (state_q == ENG_RUN)) begin
            ovr_q <= 1'b1;
         end
         if (ov_valid_q && out_ready) begin
            ov_valid_q <= 1'b0;
         end
         case (state_q)
            ENG_IDLE: begin
               if (tick) begin
                  state_q <= ENG_RUN;
                  idx_q   <= '0;
               end
            end
            ENG_RUN: begin
               if (proceed) begin
                  if (fire) begin
                     ov_valid_q <= 1'b1;
                     ov_idx_q   <= idx_q;
                  end
                  if (last) begin
                     state_q <= ENG_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < N_NEU; n++) begin
            pot_q[n] <= '0;
         end
      end else if (step) begin
         pot_q[idx_q] <= pot_next;
      end
   end

   assign busy       = (state_q == ENG_RUN);
   assign done       = done_q;
   assign overrun    = ovr_q;
   assign out_valid  = ov_valid_q;
   assign out_neuron = ov_idx_q;

endmodule

// File: rtl/neu_core_chk.sv
module neu_core_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             busy,
   input logic             done,
   input logic             overrun,
   input logic             out_valid,
   input logic             out_ready,
   input logic [IDX_W-1:0] out_neuron
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done && !overrun && !out_valid)); // R1

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_neuron))); // R9

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && busy) |=> overrun); // R7

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tick)); // R8

endmodule

bind neu_core neu_core_chk #(.IDX_W(IDX_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .busy       (busy),
   .done       (done),
   .overrun    (overrun),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_neuron (out_neuron)
);

// File: tb/neu_core_tb_top.sv
module neu_core_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NN = 256;
   localparam int NA = 256;
   localparam longint PMAX = 524287;
   localparam longint PMIN = -524288;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [2:0]   cfg_kind = '0;
   logic [7:0]   cfg_addr = '0;
   logic [1:0]   cfg_sub = '0;
   logic [8:0]   cfg_data = '0;
   logic [255:0] cfg_row = '0;
   logic         spk_valid = 1'b0;
   logic [7:0]   spk_axon = '0;
   logic         tick = 1'b0;
   logic         busy, done, overrun, out_valid;
   logic         out_ready = 1'b1;
   logic [7:0]   out_neuron;

   neu_core dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
      .cfg_addr(cfg_addr), .cfg_sub(cfg_sub), .cfg_data(cfg_data),
      .cfg_row(cfg_row), .spk_valid(spk_valid), .spk_axon(spk_axon),
      .tick(tick), .busy(busy), .done(done), .overrun(overrun),
      .out_valid(out_valid), .out_ready(out_ready), .out_neuron(out_neuron)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int done_cnt = 0;
   int hold_bad = 0;
   int cap_q[$];
   int exp_q[$];
   bit rdy_rand = 1'b0;

   // reference model state
   bit [255:0] m_xbar [NN];
   int         m_typ  [NA];
   int         m_w    [NN][4];
   int         m_leak [NN];
   int         m_thr  [NN];
   int         m_rst  [NN];
   longint     m_pot  [NN];
   bit [255:0] m_pend;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit has_spk(input int n);
      foreach (cap_q[i]) if (cap_q[i] == n) return 1'b1;
      return 1'b0;
   endfunction

   // ready driver and monitors
   always @(posedge clk) begin
      #1;
      out_ready = rdy_rand ? (($urandom % 10) < 7) : 1'b1;
   end

   bit         pv = 1'b0, pr = 1'b0;
   logic [7:0] pn = '0;
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (pv && !pr && !(out_valid && out_neuron == pn)) hold_bad++;
         pv = out_valid; pr = out_ready; pn = out_neuron;
         if (out_valid && out_ready) cap_q.push_back(int'(out_neuron));
         if (done) done_cnt++;
      end
   end

   initial begin
      while (cycles < 150000) @(negedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // configuration helpers (R10 encodings)
   task automatic cfg_wr(input int kind, input int addr, input int sub, input int data,
                         input logic [255:0] row);
      cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_addr = 8'(addr);
      cfg_sub = 2'(sub); cfg_data = 9'(data); cfg_row = row;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic set_row(input int n, input logic [255:0] r);
      cfg_wr(0, n, 0, 0, r); m_xbar[n] = r;
   endtask
   task automatic set_type(input int a, input int t);
      cfg_wr(1, a, 0, t, '0); m_typ[a] = t;
   endtask
   task automatic set_w(input int n, input int t, input int v);
      cfg_wr(2, n, t, v, '0); m_w[n][t] = v;
   endtask
   task automatic set_all_w(input int n, input int v);
      for (int t = 0; t < 4; t++) set_w(n, t, v);
   endtask
   task automatic set_leak(input int n, input int v);
      cfg_wr(3, n, 0, v, '0); m_leak[n] = v;
   endtask
   task automatic set_thr(input int n, input int v);
      cfg_wr(4, n, 0, v, '0); m_thr[n] = v;
   endtask
   task automatic set_rst(input int n, input int v);
      cfg_wr(5, n, 0, v, '0); m_rst[n] = v;
   endtask

   task automatic send_spike(input int a);
      spk_valid = 1'b1; spk_axon = 8'(a);
      @(posedge clk); #1;
      spk_valid = 1'b0;
      m_pend[a] = 1'b1;
   endtask

   // expected event list for one tick, ascending neuron order
   task automatic model_tick();
      exp_q.delete();
      for (int n = 0; n < NN; n++) begin
         longint v = m_pot[n];
         for (int a = 0; a < NA; a++)
            if (m_pend[a] && m_xbar[n][a]) v += m_w[n][m_typ[a]];
         v -= m_leak[n];
         if (v > PMAX) v = PMAX;
         if (v < PMIN) v = PMIN;
         if (v > m_thr[n]) begin
            m_pot[n] = m_rst[n];
            exp_q.push_back(n);
         end else begin
            m_pot[n] = v;
         end
      end
      m_pend = '0;
   endtask

   // mode 0 plain, 1 late spike on late_ax, 2 late spike plus overlapping tick
   task automatic do_tick(input string tag, input int mode, input int late_ax);
      int d0;
      int cnt;
      model_tick();
      cap_q.delete();
      d0 = done_cnt;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      if (mode >= 1) begin
         repeat (3) @(posedge clk);
         #1;
         send_spike(late_ax);
      end
      if (mode == 2) begin
         tick = 1'b1;
         @(posedge clk); #1;
         tick = 1'b0;
         @(negedge clk);
         check(overrun === 1'b1, "R7 overrun set by tick during sweep", overrun, 1);
      end
      cnt = 0;
      while (done_cnt == d0 && cnt < 5000) begin
         @(posedge clk); cnt++;
      end
      @(negedge clk);
      while (out_valid) @(negedge clk);
      repeat (4) @(negedge clk);
      @(posedge clk); #1;
      check(done_cnt == d0 + 1, {tag, " R8 single done per tick"}, done_cnt - d0, 1);
      check(busy === 1'b0, {tag, " R8 idle after done"}, busy, 0);
      check(cap_q.size() == exp_q.size(), {tag, " R2/R4 event count"}, cap_q.size(), exp_q.size());
      if (cap_q.size() == exp_q.size()) begin
         for (int i = 0; i < exp_q.size(); i++)
            if (cap_q[i] != exp_q[i]) begin
               check(1'b0, {tag, " R8 event order/index"}, cap_q[i], exp_q[i]);
               break;
            end
      end
   endtask

   initial begin
      int first_fire;
      void'($urandom(32'd20240611));
      for (int n = 0; n < NN; n++) begin
         m_xbar[n] = '0; m_leak[n] = 0; m_thr[n] = 0; m_rst[n] = 0; m_pot[n] = 0;
         for (int t = 0; t < 4; t++) m_w[n][t] = 0;
      end
      for (int a = 0; a < NA; a++) m_typ[a] = 0;
      m_pend = '0;

      repeat (3) @(posedge clk);
      #1;
      // R1: quiet after reset
      check(busy === 1'b0 && done === 1'b0 && overrun === 1'b0 && out_valid === 1'b0,
            "R1 outputs low in reset", {busy, done, overrun, out_valid}, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      do_tick("R1 empty tick", 0, 0);
      check(cap_q.size() == 0, "R1 no spike from reset state", cap_q.size(), 0);

      // random axon types, then directed overrides
      for (int a = 0; a < NA; a++) set_type(a, int'($urandom % 4));

      // R2: crossbar and type select, neuron 5
      set_type(3, 2); set_type(7, 1); set_type(9, 0);
      set_row(5, (256'(1) << 3) | (256'(1) << 7));
      set_w(5, 0, 100); set_w(5, 1, 10); set_w(5, 2, 20); set_w(5, 3, 1);
      set_thr(5, 25);
      send_spike(3); send_spike(9);
      do_tick("R2 unconnected axon", 0, 0);
      check(!has_spk(5), "R2 neuron5 sum 20 not fire", has_spk(5), 0);
      send_spike(7);
      do_tick("R2 type weight", 0, 0);
      check(has_spk(5), "R2 neuron5 fires with type1+type2", has_spk(5), 1);

      // R4: strict comparison, neuron 6
      set_row(6, 256'(1) << 20); set_all_w(6, 8); set_thr(6, 16); set_rst(6, -4);
      send_spike(20);
      do_tick("R4 below", 0, 0);
      send_spike(20);
      do_tick("R4 equal", 0, 0);
      check(!has_spk(6), "R4 equal to threshold does not fire", has_spk(6), 0);
      send_spike(20);
      do_tick("R4 above", 0, 0);
      check(has_spk(6), "R4 above threshold fires", has_spk(6), 1);

      // R3: leak-only drift, neuron 7 (leak -3, thr 7 -> fires on third tick)
      set_leak(7, -3); set_thr(7, 7);
      first_fire = 0;
      for (int k = 1; k <= 3; k++) begin
         do_tick("R3 leak", 0, 0);
         if (has_spk(7) && first_fire == 0) first_fire = k;
      end
      check(first_fire == 3, "R3 leak applied once per tick", first_fire, 3);

      // R6: late spike goes to next tick, then cleared; neuron 12
      set_row(12, 256'(1) << 40); set_all_w(12, 100); set_thr(12, 50);
      rdy_rand = 1'b1;
      do_tick("R6 late", 1, 40);
      check(!has_spk(12), "R6 late spike not in current tick", has_spk(12), 0);
      do_tick("R6 next", 0, 0);
      check(has_spk(12), "R6 late spike applied next tick", has_spk(12), 1);
      do_tick("R6 cleared", 0, 0);
      check(!has_spk(12), "R6 bank cleared after use", has_spk(12), 0);

      // R7: overlapping tick is ignored
      do_tick("R7 overlap", 2, 40);
      do_tick("R7 after", 0, 0);
      check(has_spk(12), "R7 late spike survives ignored tick", has_spk(12), 1);
      check(overrun === 1'b1, "R7 overrun sticky", overrun, 1);

      // R10: reconfigure reset value and threshold through the write port
      set_thr(12, 150); set_rst(12, 40);
      send_spike(40);
      do_tick("R10 reconfig a", 0, 0);
      send_spike(40);
      do_tick("R10 reconfig b", 0, 0);
      check(has_spk(12), "R10 new threshold 150 crossed at 200", has_spk(12), 1);

      // R5: negative saturation, neuron 10, then recovery
      set_row(10, '1); set_all_w(10, -256); set_thr(10, 0); set_leak(10, 0);
      for (int k = 0; k < 9; k++) begin
         for (int a = 0; a < NA; a++) send_spike(a);
         do_tick("R5 sink", 0, 0);
      end
      set_all_w(10, 255);
      first_fire = 0;
      for (int k = 1; k <= 9; k++) begin
         for (int a = 0; a < NA; a++) send_spike(a);
         do_tick("R5 rise", 0, 0);
         if (has_spk(10) && first_fire == 0) first_fire = k;
      end
      check(first_fire == 9, "R5 clamp at -524288 then fire on 9th rise tick", first_fire, 9);

      // random mixed configuration and traffic
      for (int n = 100; n < 132; n++) begin
         logic [255:0] r;
         for (int q = 0; q < 8; q++) r[q*32 +: 32] = $urandom;
         set_row(n, r);
         for (int t = 0; t < 4; t++) set_w(n, t, int'($urandom % 512) - 256);
         set_leak(n, int'($urandom % 41) - 20);
         set_thr(n, int'($urandom % 256));
         set_rst(n, int'($urandom % 512) - 256);
      end
      for (int k = 0; k < 12; k++) begin
         for (int s = 0; s < 40; s++) send_spike(int'($urandom % NA));
         do_tick("R2/R4 random", (k % 3 == 0) ? 1 : 0, int'($urandom % NA));
      end

      check(hold_bad == 0, "R9 output held while not ready", hold_bad, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule